// File: doc/BRIEF.md
# Deferred-Commit Register Store

This block holds sixteen 8-bit setting registers, grouped as four banks of four, that stand in for the nonvolatile memory behind a digitally controlled potentiometer. The serial command decoder hands it finished write requests while chip select is low. Two kinds of request exist. A host write may target any register. A wiper copy stores the current wiper value into a bank-0 register. The block holds the request in a one-entry staging slot. It applies the request on the next rising edge of chip select, and only if the write-protect input is high at that moment.

Each applied write starts a programmable busy window that models the slow cell programming time. A write-in-progress flag stays high for the whole window, and any write or copy request that arrives during it is dropped. Reads are always served. There is a host read port over all sixteen registers, a bank-0-only read port that feeds register-to-wiper transfers, and a constant output that carries bank 0 register 0 as the power-up wiper value. The soft reset clears only the control state. The register contents change only through commits or through a separate preload port meant for test.

Top module: `nvs_store`

## Requirements
- R1: rd_data_o shows, in the same cycle, the register selected by rd_addr_i. The address is {bank[1:0], reg[1:0]}, with the bank in the upper two bits.
- R2: A host write accepted while cs_ni is low leaves every register unchanged while cs_ni stays low. On the first clock edge at which cs_ni is sampled high after being low, the register gets the data, and the new value is visible after that edge.
- R3: A wiper copy request (cp_vld_i) writes wiper_i into bank 0, register cp_sel_i, at commit. It never reaches banks 1 to 3.
- R4: wip_o goes high right after the commit edge. It stays high for exactly WR_CYCLES clock cycles and then reads 0.
- R5: Write and copy requests that arrive while wip_o is 1 are dropped. The contents do not change and no further busy window follows.
- R6: If wp_ni is low at the commit edge, the staged request is discarded. No register changes and wip_o stays 0.
- R7: A rise of chip select with nothing staged changes no register and raises no busy window. Every clock edge with cs_ni high empties the staging slot.
- R8: boot_val_o always equals bank 0 register 0. xfer_data_o always equals bank 0 register xfer_sel_i.
- R9: rst_ni low clears the staging slot and the busy window but keeps the register contents.
- R10: pl_en_i writes pl_data_i into register pl_addr_i at the next edge, whatever the busy or protect state. When it targets the same register as a commit in the same cycle, the preload value wins.
- R11: If a host write and a wiper copy are both offered in one cycle, the host write is staged. A later request in the same chip-select window replaces an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the control state |
| cs_ni | input | 1 | Chip select, active low; its rise commits the staged write |
| wp_ni | input | 1 | Write protect, active low |
| wr_vld_i | input | 1 | Host write request |
| wr_addr_i | input | 4 | Host write register address {bank, reg} |
| wr_data_i | input | 8 | Host write data |
| cp_vld_i | input | 1 | Wiper-to-register copy request |
| cp_sel_i | input | 2 | Bank-0 register for the copy |
| wiper_i | input | 8 | Current wiper value |
| rd_addr_i | input | 4 | Host read address {bank, reg} |
| rd_data_o | output | 8 | Host read data |
| xfer_sel_i | input | 2 | Bank-0 register feeding a transfer to the wiper |
| xfer_data_o | output | 8 | Transfer source data |
| boot_val_o | output | 8 | Power-up wiper value (bank 0 register 0) |
| wip_o | output | 1 | Write in progress |
| pl_en_i | input | 1 | Test preload enable |
| pl_addr_i | input | 4 | Test preload address |
| pl_data_i | input | 8 | Test preload data |

## Verification
Two things can hit the storage in the same cycle: a commit on the chip-select rise and a test preload. The bench raises chip select and pulses the preload on the same falling clock edge, aimed at the register that is staged. It then expects the preload value in that register and a busy window that still runs its full length. A second collision is a request and its commit arriving during a running busy window. For this case the bench runs a complete chip-select window inside the busy period and, after the window closes, checks that the target register is unchanged and that wip_o stays low.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_HOST  = 2'd1,
    SRC_WIPER = 2'd2
  } wsrc_e;
endpackage

// File: rtl/nvs_pending.sv
module nvs_pending
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              clear_i,
  input  logic              wr_vld_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cp_vld_i,
  input  logic [ADDR_W-1:0] cp_addr_i,
  input  logic [DATA_W-1:0] cp_data_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  wsrc_e src;

  always_comb begin
    if (!accept_i)     src = SRC_NONE;
    else if (wr_vld_i) src = SRC_HOST;   // host beats copy
    else if (cp_vld_i) src = SRC_WIPER;
    else               src = SRC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else if (clear_i) begin
      vld_o <= 1'b0;
    end else begin
      case (src)
        SRC_HOST: begin
          vld_o  <= 1'b1;
          addr_o <= wr_addr_i;
          data_o <= wr_data_i;
        end
        SRC_WIPER: begin
          vld_o  <= 1'b1;
          addr_o <= cp_addr_i;
          data_o <= cp_data_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 4,
  parameter int SEL_W    = 2,
  parameter int DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pl_en_i,
  input  logic [ADDR_W-1:0] pl_addr_i,
  input  logic [DATA_W-1:0] pl_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [SEL_W-1:0]  xfer_sel_i,
  output logic [DATA_W-1:0] xfer_data_o,
  output logic [DATA_W-1:0] boot_val_o
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  // no reset: contents outlive the control reset
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i) begin
      if (pl_en_i && pl_addr_i == ADDR_W'(g))   regs[g] <= pl_data_i;
      else if (we_i && waddr_i == ADDR_W'(g))   regs[g] <= wdata_i;
    end
  end

  assign rd_data_o   = regs[rd_addr_i];
  assign xfer_data_o = regs[{{(ADDR_W-SEL_W){1'b0}}, xfer_sel_i}];
  assign boot_val_o  = regs[0];
endmodule

// File: rtl/nvs_store.sv
module nvs_store #(
  parameter int NUM_BANKS     = 4,
  parameter int REGS_PER_BANK = 4,
  parameter int DATA_W        = 8,
  parameter int WR_CYCLES     = 2_500_000
) (
  input  logic                                                   clk_i,
  input  logic                                                   rst_ni,
  input  logic                                                   cs_ni,
  input  logic                                                   wp_ni,
  input  logic                                                   wr_vld_i,
  input  logic [$clog2(NUM_BANKS)+$clog2(REGS_PER_BANK)-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]                                      wr_data_i,
  input  logic                                                   cp_vld_i,
  input  logic [$clog2(REGS_PER_BANK)-1:0]                       cp_sel_i,
  input  logic [DATA_W-1:0]                                      wiper_i,
  input  logic [$clog2(NUM_BANKS)+$clog2(REGS_PER_BANK)-1:0]     rd_addr_i,
  output logic [DATA_W-1:0]                                      rd_data_o,
  input  logic [$clog2(REGS_PER_BANK)-1:0]                       xfer_sel_i,
  output logic [DATA_W-1:0]                                      xfer_data_o,
  output logic [DATA_W-1:0]                                      boot_val_o,
  output logic                                                   wip_o,
  input  logic                                                   pl_en_i,
  input  logic [$clog2(NUM_BANKS)+$clog2(REGS_PER_BANK)-1:0]     pl_addr_i,
  input  logic [DATA_W-1:0]                                      pl_data_i
);
  localparam int BANK_W   = $clog2(NUM_BANKS);
  localparam int SEL_W    = $clog2(REGS_PER_BANK);
  localparam int ADDR_W   = BANK_W + SEL_W;
  localparam int NUM_REGS = NUM_BANKS * REGS_PER_BANK;

  logic              cs_q;
  logic              cs_rise;
  logic              busy;
  logic              commit;
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b1;
    else         cs_q <= cs_ni;
  end

  assign cs_rise = cs_ni & ~cs_q;
  assign commit  = cs_rise & pend_vld & wp_ni & ~busy;

  nvs_pending #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pending (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (~cs_ni & ~busy),
    .clear_i   (cs_ni),
    .wr_vld_i  (wr_vld_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cp_vld_i  (cp_vld_i),
    .cp_addr_i ({{BANK_W{1'b0}}, cp_sel_i}),
    .cp_data_i (wiper_i),
    .vld_o     (pend_vld),
    .addr_o    (pend_addr),
    .data_o    (pend_data)
  );

  nvs_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .busy_o  (busy)
  );

  nvs_array #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .SEL_W    (SEL_W),
    .DATA_W   (DATA_W)
  ) u_array (
    .clk_i       (clk_i),
    .we_i        (commit),
    .waddr_i     (pend_addr),
    .wdata_i     (pend_data),
    .pl_en_i     (pl_en_i),
    .pl_addr_i   (pl_addr_i),
    .pl_data_i   (pl_data_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .xfer_sel_i  (xfer_sel_i),
    .xfer_data_o (xfer_data_o),
    .boot_val_o  (boot_val_o)
  );

  assign wip_o = busy;
endmodule

// File: rtl/nvs_store_chk.sv
module nvs_store_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              cs_q_i,
  input logic              wp_ni,
  input logic              pl_en_i,
  input logic              pend_vld_i,
  input logic              wip_i,
  input logic [DATA_W-1:0] boot_val_i
);
  AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !cs_q_i && pend_vld_i && wp_ni && !wip_i) |=> wip_i); // R4

  AST_NOTHING_STAGED_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_i |-> !pend_vld_i); // R5

  AST_PROTECT_KEEPS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wip_i && !wp_ni) |=> !wip_i); // R6

  AST_CS_HIGH_EMPTIES_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !pend_vld_i); // R7

  AST_NO_CHANGE_WHILE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !pl_en_i) |=> $stable(boot_val_i)); // R2
endmodule

bind nvs_store nvs_store_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .cs_q_i     (cs_q),
  .wp_ni      (wp_ni),
  .pl_en_i    (pl_en_i),
  .pend_vld_i (pend_vld),
  .wip_i      (wip_o),
  .boot_val_i (boot_val_o)
);

// File: tb/nvs_store_bench.sv
`timescale 1ns/1ps
module nvs_store_bench;
  localparam int W = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       wp_ni = 1'b1;
  logic       wr_vld_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       cp_vld_i = 1'b0;
  logic [1:0] cp_sel_i = '0;
  logic [7:0] wiper_i = '0;
  logic [3:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic [1:0] xfer_sel_i = '0;
  logic [7:0] xfer_data_o;
  logic [7:0] boot_val_o;
  logic       wip_o;
  logic       pl_en_i = 1'b0;
  logic [3:0] pl_addr_i = '0;
  logic [7:0] pl_data_i = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] exp_q [16];

  always #2 clk_i = ~clk_i;

  nvs_store #(.WR_CYCLES(W)) u_nvs_store (.*);

  function automatic logic [7:0] seed_val(int a);
    return 8'(a * 17 + 3);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic preload(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i);
    pl_en_i = 1'b1; pl_addr_i = a; pl_data_i = d;
    @(negedge clk_i);
    pl_en_i = 1'b0;
    exp_q[a] = d;
  endtask

  // R1 R8: sweep all read ports against the model
  task automatic check_regs();
    for (int a = 0; a < 16; a++) begin
      rd_addr_i = 4'(a);
      #0.1;
      chk("R1 read", rd_data_o, exp_q[a]);
    end
    for (int s = 0; s < 4; s++) begin
      xfer_sel_i = 2'(s);
      #0.1;
      chk("R8 xfer", xfer_data_o, exp_q[s]);
    end
    chk("R8 boot", boot_val_o, exp_q[0]);
  endtask

  // R4: called right after the commit edge
  task automatic watch_busy(bit expect_busy);
    bit ok = 1;
    for (int k = 1; k <= W; k++) begin
      @(negedge clk_i);
      if (wip_o !== expect_busy) ok = 0;
    end
    chk(expect_busy ? "R4 wip high window" : "R6 R7 wip idle", ok, 1);
    @(negedge clk_i);
    chk("R4 wip released", wip_o, 0);
  endtask

  // kind: 0 none, 1 host, 2 copy, 3 both (host wins, R11)
  task automatic run_seq(int kind, logic [3:0] a, logic [7:0] d, bit wp);
    logic [3:0] tgt;
    @(negedge clk_i);
    cs_ni = 1'b0;
    @(negedge clk_i);
    wr_vld_i = (kind == 1 || kind == 3);
    wr_addr_i = a; wr_data_i = d;
    cp_vld_i = (kind == 2 || kind == 3);
    cp_sel_i = a[1:0]; wiper_i = (kind == 3) ? ~d : d;
    @(negedge clk_i);
    wr_vld_i = 1'b0; cp_vld_i = 1'b0;
    wp_ni = wp;
    tgt = (kind == 2) ? {2'b00, a[1:0]} : a;
    rd_addr_i = tgt;
    #0.1;
    chk("R2 not visible before release", rd_data_o, exp_q[tgt]);
    @(negedge clk_i);
    cs_ni = 1'b1;
    @(posedge clk_i);
    if (kind != 0 && wp) exp_q[tgt] = d;
    watch_busy(kind != 0 && wp);
    wp_ni = 1'b1;
    check_regs();
  endtask

  initial begin
    void'($urandom(32'd4242));
    #9 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 reset wip", wip_o, 0);
    for (int a = 0; a < 16; a++) preload(4'(a), seed_val(a));
    check_regs();

    // directed
    run_seq(1, 4'hB, 8'h5A, 1'b1);        // R2 host write, bank 2
    run_seq(2, 4'h6, 8'hC3, 1'b1);        // R3 copy forced into bank 0
    run_seq(3, 4'h1, 8'h96, 1'b1);        // R11 host beats copy
    run_seq(1, 4'h3, 8'h0F, 1'b0);        // R6 protected
    run_seq(0, 4'h0, 8'h00, 1'b1);        // R7 empty window

    // R11 later request replaces earlier
    @(negedge clk_i); cs_ni = 1'b0;
    @(negedge clk_i); wr_vld_i = 1'b1; wr_addr_i = 4'h7; wr_data_i = 8'h11;
    @(negedge clk_i); wr_addr_i = 4'h8; wr_data_i = 8'h22;
    @(negedge clk_i); wr_vld_i = 1'b0;
    @(negedge clk_i); cs_ni = 1'b1;
    @(posedge clk_i); exp_q[8] = 8'h22;
    watch_busy(1);
    check_regs();

    // R5 full window inside busy is dropped
    @(negedge clk_i); cs_ni = 1'b0;
    @(negedge clk_i); wr_vld_i = 1'b1; wr_addr_i = 4'h5; wr_data_i = 8'hAA;
    @(negedge clk_i); wr_vld_i = 1'b0;
    @(negedge clk_i); cs_ni = 1'b1;
    @(posedge clk_i); exp_q[5] = 8'hAA;
    @(negedge clk_i); cs_ni = 1'b0;
    @(negedge clk_i); wr_vld_i = 1'b1; wr_addr_i = 4'h6; wr_data_i = 8'h55;
    @(negedge clk_i); wr_vld_i = 1'b0;
    @(negedge clk_i); cs_ni = 1'b1;
    repeat (W + 2) @(negedge clk_i);
    chk("R5 no second busy", wip_o, 0);
    rd_addr_i = 4'h6; #0.1;
    chk("R5 dropped write", rd_data_o, exp_q[6]);
    check_regs();

    // R9 reset discards staged write, keeps contents
    @(negedge clk_i); cs_ni = 1'b0;
    @(negedge clk_i); wr_vld_i = 1'b1; wr_addr_i = 4'h2; wr_data_i = 8'hEE;
    @(negedge clk_i); wr_vld_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); cs_ni = 1'b1;
    @(posedge clk_i);
    watch_busy(0);
    check_regs();

    // R10 preload and commit collide on one register
    @(negedge clk_i); cs_ni = 1'b0;
    @(negedge clk_i); wr_vld_i = 1'b1; wr_addr_i = 4'h9; wr_data_i = 8'h33;
    @(negedge clk_i); wr_vld_i = 1'b0;
    @(negedge clk_i); cs_ni = 1'b1;
    pl_en_i = 1'b1; pl_addr_i = 4'h9; pl_data_i = 8'h44;
    @(posedge clk_i); exp_q[9] = 8'h44;
    @(negedge clk_i); pl_en_i = 1'b0;
    chk("R10 commit still busy", wip_o, 1);
    rd_addr_i = 4'h9; #0.1;
    chk("R10 preload wins", rd_data_o, 8'h44);
    repeat (W) @(negedge clk_i);
    chk("R4 wip released", wip_o, 0);
    check_regs();

    // random mix
    for (int it = 0; it < 40; it++) begin
      run_seq(int'($urandom_range(0, 3)), 4'($urandom_range(0, 15)),
              8'($urandom_range(0, 255)), ($urandom_range(0, 3) != 0));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #190000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule